// File: doc/BRIEF.md
# Temperature Sensor Power Sequencer

This block drives the supply-side control lines of an on-chip analog temperature sensor. A one-word mode write asks for the sensor to be on or off. Turning it on is a timed two-step sequence. The sensor enable line goes high first. Output enable follows only after a programmable settling interval. A second settling interval then passes before the block raises its ready flag. Turning it off drops every line in one clock, even when the sequence is only partly done.

Time is measured in whole microseconds from an external one-cycle `us_tick` strobe. Each interval is counted conservatively, so at least the programmed number of full microseconds always passes.

The block also manages a low-power sleep handshake. On sleep it first switches the sensor off and then holds the sensor reset. On wake it releases the reset first. It replays the power-up sequence only when the remembered mode is "on".

Top module: `tsu_pwr_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `sens_en`, `sens_oe` and `sens_ready` low, `sens_rst_n` high, and the remembered mode off.
- R2: A write (`wr_en`=1) with `wr_data[0]`=1 while idle raises `sens_en` alone at the next edge, with `sens_oe` still low.
- R3: `sens_oe` rises at the edge that samples the (EN_SETTLE_US+1)-th `us_tick` counted from the first cycle in which `sens_en` is high. This gives at least EN_SETTLE_US full microseconds.
- R4: `sens_ready` rises at the edge that samples the (OE_SETTLE_US+1)-th `us_tick` counted from the first cycle in which `sens_oe` is high. It is never high unless both sensor lines are high.
- R5: A write with `wr_data[0]`=0 clears `sens_en`, `sens_oe` and `sens_ready` together at the next edge. This holds in every phase of the sequence, including in the middle of either wait.
- R6: A write that asks for the mode already in force has no effect. An "on" write during a wait does not restart its timing, and an "off" write while idle changes nothing.
- R7: When `sleep_req` is sampled high outside sleep, both sensor lines and ready drop at the next edge. `sens_rst_n` drops one edge later and stays low while `sleep_req` stays high.
- R8: When `sleep_req` is sampled low during sleep, `sens_rst_n` rises at the next edge. One edge later, `sens_en` rises if the remembered mode is on; otherwise all lines stay low.
- R9: Writes made during sleep change no output line but update the remembered mode that R8 acts on.
- R10: `wr_data[1]` is ignored. Only the sequencer drives `sens_oe`, so a write of 2'b10 counts as an "off" request and a write of 2'b11 as an "on" request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Mode write strobe |
| wr_data | input | 2 | Mode word: bit 0 requests on (1) or off (0); bit 1 ignored |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| sleep_req | input | 1 | High requests low-power sleep, low requests wake |
| sens_en | output | 1 | Sensor enable line |
| sens_oe | output | 1 | Sensor output-enable line |
| sens_ready | output | 1 | Sensor settled and usable |
| sens_rst_n | output | 1 | Active-low reset to the sensor |

## Verification
The hardest cases to reach are a wake with the remembered mode changed during sleep, and an "off" request that lands inside the output-enable wait. Both need a long, tick-paced run to set up first. The stimulus drives the sequence fully on, then sleeps and wakes once with the mode unchanged. It then sleeps again with an "off" and an "on" write made during sleep, and a final sleep carries an "off" write alone. Separately, it starts a fresh sequence and issues the "off" write part-way through the second wait. A behavioural model in the bench compares all four outputs on every clock. Each phase is tagged with the requirement it targets.

// File: rtl/tsu_pwr_pkg.sv
// Package: shared state type for the sensor power sequencer.
package tsu_pwr_pkg;

    // Sequencer phases; sensor lines are decoded from these.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_EN_WAIT = 3'd1,
        ST_OE_WAIT = 3'd2,
        ST_RUN     = 3'd3,
        ST_SLP_OFF = 3'd4,
        ST_SLP     = 3'd5,
        ST_WAKE    = 3'd6
    } seq_state_e;

endpackage

// File: rtl/tsu_pwr_timer.sv
// Module: tsu_pwr_timer
// Counts microsecond ticks against one of two settling limits.
// Assumes: clr is asserted by the controller on every phase change, so
// the count always starts at zero on entry to a wait phase. done is high
// in the cycle whose tick completes limit+1 ticks since the clear.
module tsu_pwr_timer #(
    parameter int EN_SETTLE_US = 30,
    parameter int OE_SETTLE_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic sel_oe,
    output logic done
);
    localparam int MAX_US = (EN_SETTLE_US > OE_SETTLE_US) ? EN_SETTLE_US : OE_SETTLE_US;
    localparam int CNT_W  = $clog2(MAX_US + 1) + 1;
    localparam logic [CNT_W-1:0] EN_LIM = CNT_W'(EN_SETTLE_US);
    localparam logic [CNT_W-1:0] OE_LIM = CNT_W'(OE_SETTLE_US);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Pick the limit for the wait phase in progress.
    always_comb limit = sel_oe ? OE_LIM : EN_LIM;

    // Flag the tick that ends the wait.
    always_comb done = tick && (cnt_q == limit);

    // Tick counter: cleared on phase change, saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tsu_pwr_fsm.sv
// Module: tsu_pwr_fsm
// Phase controller: power-up sequence, immediate abort, sleep handshake
// and mode memory. Assumes the timer is cleared by tmr_clr on every
// phase change. Priority: sleep, then an "off" write, then timer expiry.
module tsu_pwr_fsm
    import tsu_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_on,
    input  logic       sleep_req,
    input  logic       tmr_done,
    output logic       tmr_clr,
    output logic       tmr_sel_oe,
    output seq_state_e state
);
    seq_state_e state_q, state_d;
    logic       mode_q, mode_d;

    // Remembered mode follows every write, including during sleep.
    always_comb mode_d = wr_en ? wr_on : mode_q;

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        if (sleep_req && (state_q != ST_SLP_OFF) && (state_q != ST_SLP)) begin
            state_d = ST_SLP_OFF;
        end else begin
            case (state_q)
                ST_IDLE:    if (wr_en && wr_on) state_d = ST_EN_WAIT;
                ST_EN_WAIT: if (wr_en && !wr_on) state_d = ST_IDLE;
                            else if (tmr_done) state_d = ST_OE_WAIT;
                ST_OE_WAIT: if (wr_en && !wr_on) state_d = ST_IDLE;
                            else if (tmr_done) state_d = ST_RUN;
                ST_RUN:     if (wr_en && !wr_on) state_d = ST_IDLE;
                ST_SLP_OFF: state_d = ST_SLP;
                ST_SLP:     if (!sleep_req) state_d = ST_WAKE;
                ST_WAKE:    state_d = mode_d ? ST_EN_WAIT : ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // Timer control: restart on any phase change, long limit in OE wait.
    always_comb begin
        tmr_clr    = (state_d != state_q);
        tmr_sel_oe = (state_q == ST_OE_WAIT);
    end

    // Phase and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    // Expose the phase for output decoding.
    always_comb state = state_q;
endmodule

// File: rtl/tsu_pwr_seq.sv
// Module: tsu_pwr_seq (top)
// Sensor power sequencer: enable, settle, output enable, settle, ready;
// immediate shut-off on an "off" write; sleep/wake handshake on the
// sensor reset. Assumes us_tick is a single-cycle pulse, synchronous
// to clk. Outputs are decoded from the registered phase only.
module tsu_pwr_seq
    import tsu_pwr_pkg::*;
#(
    parameter int EN_SETTLE_US = 30,
    parameter int OE_SETTLE_US = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    input  logic       us_tick,
    input  logic       sleep_req,
    output logic       sens_en,
    output logic       sens_oe,
    output logic       sens_ready,
    output logic       sens_rst_n
);
    seq_state_e state;
    logic       tmr_clr, tmr_sel_oe, tmr_done;
    logic       unused_oe_field;

    // Bit 1 of the mode word is owned by the sequencer; writes ignore it.
    assign unused_oe_field = wr_data[1];

    tsu_pwr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_on      (wr_data[0]),
        .sleep_req  (sleep_req),
        .tmr_done   (tmr_done),
        .tmr_clr    (tmr_clr),
        .tmr_sel_oe (tmr_sel_oe),
        .state      (state)
    );

    tsu_pwr_timer #(
        .EN_SETTLE_US (EN_SETTLE_US),
        .OE_SETTLE_US (OE_SETTLE_US)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .tick   (us_tick),
        .sel_oe (tmr_sel_oe),
        .done   (tmr_done)
    );

    // Decode the sensor lines from the phase.
    always_comb begin
        sens_en    = (state == ST_EN_WAIT) || (state == ST_OE_WAIT) || (state == ST_RUN);
        sens_oe    = (state == ST_OE_WAIT) || (state == ST_RUN);
        sens_ready = (state == ST_RUN);
        sens_rst_n = (state != ST_SLP);
    end
endmodule

// File: rtl/tsu_pwr_seq_chk.sv
// Module: tsu_pwr_seq_chk
// Port-level temporal checks for tsu_pwr_seq, attached by bind.
module tsu_pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_data,
    input logic       us_tick,
    input logic       sleep_req,
    input logic       sens_en,
    input logic       sens_oe,
    input logic       sens_ready,
    input logic       sens_rst_n
);
    // R2
    en_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sens_en) |-> !sens_oe);

    // R3
    oe_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sens_oe) |-> ($past(sens_en) && $past(us_tick)));

    // R4
    ready_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sens_ready) |-> ($past(sens_oe) && $past(us_tick)));

    // R4
    ready_needs_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sens_ready |-> (sens_en && sens_oe));

    // R5
    off_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[0]) |=> (!sens_en && !sens_oe && !sens_ready));

    // R7
    sleep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_req) |=> (!sens_en && !sens_oe));

    // R7
    rst_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sens_rst_n) |-> ($past(!sens_en) && $past(sleep_req)));

    // R8
    wake_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sens_rst_n) |-> $past(!sleep_req));

    // R10
    oe_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sens_oe |-> sens_en);
endmodule

bind tsu_pwr_seq tsu_pwr_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .us_tick    (us_tick),
    .sleep_req  (sleep_req),
    .sens_en    (sens_en),
    .sens_oe    (sens_oe),
    .sens_ready (sens_ready),
    .sens_rst_n (sens_rst_n)
);

// File: tb/tsu_pwr_seq_tb.sv
module tsu_pwr_seq_tb;
    localparam int EN_US = 30;
    localparam int OE_US = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_data = 2'b00;
    logic       us_tick = 1'b0;
    logic       sleep_req = 1'b0;
    logic       sens_en, sens_oe, sens_ready, sens_rst_n;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc_cnt = 0;
    int    tick_div = 0;
    bit    started = 1'b0;
    bit    done_flag = 1'b0;
    string cur_req = "R1";

    // Reference model: phase 0 idle, 1 enable wait, 2 OE wait, 3 running,
    // 4 sleep entry, 5 asleep, 6 waking.
    int ph = 0;
    int tcnt = 0;
    bit mode = 1'b0;

    always #5 clk = ~clk;

    tsu_pwr_seq #(.EN_SETTLE_US(EN_US), .OE_SETTLE_US(OE_US)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .us_tick(us_tick), .sleep_req(sleep_req), .sens_en(sens_en),
        .sens_oe(sens_oe), .sens_ready(sens_ready), .sens_rst_n(sens_rst_n)
    );

    // Model update at each edge from the inputs held stable since the last falling edge.
    always @(posedge clk) begin
        int  nph;
        bit  nmode;
        started = 1'b1;
        if (!rst_n) begin
            ph = 0; tcnt = 0; mode = 1'b0;
        end else begin
            nmode = wr_en ? wr_data[0] : mode;
            nph = ph;
            if (sleep_req && ph != 4 && ph != 5) nph = 4;
            else if (ph == 0) begin
                if (wr_en && wr_data[0]) nph = 1;
            end else if (ph == 1 || ph == 2) begin
                if (wr_en && !wr_data[0]) nph = 0;
                else if (us_tick) begin
                    if (tcnt == ((ph == 1) ? EN_US : OE_US)) nph = ph + 1;
                    else tcnt = tcnt + 1;
                end
            end else if (ph == 3) begin
                if (wr_en && !wr_data[0]) nph = 0;
            end else if (ph == 4) nph = 5;
            else if (ph == 5) begin
                if (!sleep_req) nph = 6;
            end else if (ph == 6) nph = nmode ? 1 : 0;
            if (nph != ph) tcnt = 0;
            ph = nph;
            mode = nmode;
        end
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, what, act, exp, cyc_cnt);
        end
    endtask

    // Compare every output to the model away from the active edge.
    always @(negedge clk) begin
        if (started && !done_flag) begin
            chk(cur_req, "sens_en",    sens_en,    (ph >= 1 && ph <= 3));
            chk(cur_req, "sens_oe",    sens_oe,    (ph == 2 || ph == 3));
            chk(cur_req, "sens_ready", sens_ready, (ph == 3));
            chk(cur_req, "sens_rst_n", sens_rst_n, (ph != 5));
        end
    end

    // Microsecond strobe: one cycle high out of every three.
    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 3;
        us_tick = (tick_div == 0);
    end

    task automatic finish_up();
        done_flag = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000 && !done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 2'b00;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 2000 && !sens_ready; i++) @(negedge clk);
    endtask

    initial begin
        // R1 reset state
        cur_req = "R1";
        cycles(5);
        chk("R1", "reset sens_en", sens_en, 1'b0);
        chk("R1", "reset sens_rst_n", sens_rst_n, 1'b1);
        rst_n = 1'b1;
        cycles(3);

        // R10 and R6: "off" while idle, with bit 1 set
        cur_req = "R10";
        wr(2'b10);
        cycles(5);
        chk("R10", "oe after 2'b10", sens_oe, 1'b0);

        // R2 start the sequence
        cur_req = "R2";
        wr(2'b01);
        chk("R2", "en after on write", sens_en, 1'b1);
        chk("R2", "oe after on write", sens_oe, 1'b0);

        // R6 repeated "on" mid wait, R3 first settle
        cur_req = "R6";
        cycles(40);
        wr(2'b11);
        cur_req = "R3";
        cycles(60);

        // R4 second settle to ready
        cur_req = "R4";
        wait_ready();
        chk("R4", "ready reached", sens_ready, 1'b1);
        cycles(10);

        // R5 off from running
        cur_req = "R5";
        wr(2'b00);
        chk("R5", "en after off write", sens_en, 1'b0);
        cycles(5);
        // R5 abort inside the OE wait
        wr(2'b01);
        cycles(130);
        chk("R5", "in OE wait", sens_oe, 1'b1);
        wr(2'b00);
        chk("R5", "oe after abort", sens_oe, 1'b0);
        // R6 "off" while already off
        cur_req = "R6";
        wr(2'b00);
        cycles(10);

        // R7 sleep from running, R8 wake replays
        cur_req = "R7";
        wr(2'b01);
        wait_ready();
        @(negedge clk); sleep_req = 1'b1;
        cycles(20);
        chk("R7", "rst held in sleep", sens_rst_n, 1'b0);
        cur_req = "R8";
        sleep_req = 1'b0;
        cycles(3);
        chk("R8", "replay en", sens_en, 1'b1);
        wait_ready();
        cycles(5);

        // R9 writes during sleep: "off" then "on" -> replay; then "off" -> idle
        cur_req = "R9";
        @(negedge clk); sleep_req = 1'b1;
        cycles(4);
        wr(2'b00);
        cycles(3);
        wr(2'b01);
        cycles(3);
        sleep_req = 1'b0;
        cycles(4);
        chk("R9", "replay after on in sleep", sens_en, 1'b1);
        cycles(20);
        sleep_req = 1'b1;
        cycles(4);
        wr(2'b00);
        cycles(3);
        sleep_req = 1'b0;
        cur_req = "R8";
        cycles(6);
        chk("R8", "no replay when off", sens_en, 1'b0);
        chk("R8", "rst released", sens_rst_n, 1'b1);
        cycles(10);

        finish_up();
    end
endmodule